// File: doc/BRIEF.md
# Victim Line Write-Back Buffer with Fill Arbitration

This block sits beside a set-associative cache and holds one dirty line that a line fill pushed out of the data array. While the line waits for its write-back, every new line fill is judged against it: the fill may go ahead, be refused, or be answered straight from the buffer without touching memory. The write-back is a burst that the cache drives as bus master. The buffer hands out its beats in order over a request/acknowledge handshake.

The buffer also tracks whether the fill that evicted its line is still in flight. If that fill is retried on the bus, the block tells the tag array to reinstate the victim's tag as valid and dirty, and it drops its own copy. Write-back starts only after the evicting fill has completed, so a rolled-back line is never written to memory.

Top module: `cob_unit`

## Requirements
- R1: After reset the buffer is empty: `cob_valid_o`, `drain_req_o` and `rb_valid_o` are low.
- R2: A load (`ld_i`) while the buffer is empty captures the line address, way and all beats, and `cob_valid_o` is high from the next cycle. Beat k of `ld_line_i` is bits [k*BEAT_W +: BEAT_W], and beat 0 is written back first.
- R3: A load while the buffer is full is ignored: the buffered address and data stay unchanged.
- R4: A fill request whose victim is dirty is cancelled (`fill_cancel_o` high, `fill_go_o` low) while the buffer is full, unless it is a write to the buffered line address.
- R5: A write fill whose line address equals the buffered one proceeds (`fill_go_o` high), even when its victim is dirty and the buffer is full.
- R6: A read fill whose line address equals the buffered one is served from the buffer: `buf_serve_o` and `fill_cancel_o` are high and `fill_go_o` is low. `rd_data_o` shows the buffered beat selected by `rd_beat_i`.
- R7: A fill request with a clean victim, or with an empty buffer, that is not served from the buffer proceeds (`fill_go_o` high).
- R8: `retry_i` while the evicting fill is still pending raises `rb_valid_o` in the same cycle, with `rb_addr_o` and `rb_way_o` giving the victim, to be restored as valid and dirty. The buffer is empty from the next cycle, even if a write fill to the buffered line had proceeded.
- R9: `drain_req_o` is high only while the buffer is full and `fill_done_i` has been seen for the evicting fill. Beats go out in order 0 to BEATS-1, and each `drain_ack_i` moves `drain_beat_o` and `drain_data_o` on to the next beat.
- R10: The buffer stays full until the last beat is acknowledged, and is empty from the cycle after that acknowledge.
- R11: `retry_i` while no evicting fill is pending has no effect: `rb_valid_o` stays low and the buffer keeps its line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_i | input | 1 | Load victim line |
| ld_addr_i | input | LA_W | Victim line address |
| ld_way_i | input | WAY_W | Victim way |
| ld_line_i | input | LINE_W | Victim line data, beat 0 in the low bits |
| fill_req_i | input | 1 | Line fill request to be judged |
| fill_write_i | input | 1 | Fill is caused by a write |
| fill_victim_dirty_i | input | 1 | Fill would replace a dirty line |
| fill_addr_i | input | LA_W | Fill line address |
| fill_done_i | input | 1 | Evicting fill completed |
| fill_go_o | output | 1 | Fill may proceed |
| fill_cancel_o | output | 1 | Fill is not performed |
| buf_serve_o | output | 1 | Read is answered from the buffer |
| rd_beat_i | input | BI_W | Beat index for read data |
| rd_data_o | output | BEAT_W | Buffered beat for reads |
| retry_i | input | 1 | Bus retry of the evicting fill |
| rb_valid_o | output | 1 | Restore victim tag as valid and dirty |
| rb_addr_o | output | LA_W | Victim line address to restore |
| rb_way_o | output | WAY_W | Victim way to restore |
| drain_req_o | output | 1 | Write-back beat offered |
| drain_ack_i | input | 1 | Write-back beat accepted |
| drain_addr_o | output | LA_W | Buffered line address |
| drain_beat_o | output | BI_W | Index of offered beat |
| drain_data_o | output | BEAT_W | Offered beat data |
| cob_valid_o | output | 1 | Buffer holds a line |

## Verification
The bench aims at a write fill to the buffered address with a dirty victim. A design that cancelled it would stall the writing processor, and one that let every dirty-victim fill through would overrun the single entry. It retries after such a write has been allowed, which catches a design that keeps the buffer or forgets to raise the restore. Drains run with random acknowledge gaps and random retries after the fill has finished. A design that freed the entry early, skipped a beat, or rolled back a line already committed would show the wrong beat, the wrong valid flag or a stray restore.

// File: rtl/cob_pkg.sv
package cob_pkg;
  typedef enum logic [1:0] {
    VERD_NONE   = 2'd0,
    VERD_GO     = 2'd1,
    VERD_CANCEL = 2'd2,
    VERD_SERVE  = 2'd3
  } fill_verdict_e;
endpackage

// File: rtl/cob_store.sv
module cob_store #(
  parameter int LA_W   = 27,
  parameter int BEAT_W = 64,
  parameter int BEATS  = 4,
  parameter int WAY_W  = 2,
  localparam int LINE_W = BEATS * BEAT_W,
  localparam int BI_W   = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_acc_i,
  input  logic [LA_W-1:0]   ld_addr_i,
  input  logic [WAY_W-1:0]  ld_way_i,
  input  logic [LINE_W-1:0] ld_line_i,
  input  logic              rb_acc_i,
  input  logic              drain_last_i,
  input  logic              fill_done_i,
  input  logic [BI_W-1:0]   rd_sel_i,
  input  logic [BI_W-1:0]   dr_sel_i,
  output logic              valid_o,
  output logic              pending_o,
  output logic [LA_W-1:0]   addr_o,
  output logic [WAY_W-1:0]  way_o,
  output logic [BEAT_W-1:0] rd_data_o,
  output logic [BEAT_W-1:0] dr_data_o
);
  logic              valid_q, pending_q;
  logic [LA_W-1:0]   addr_q;
  logic [WAY_W-1:0]  way_q;
  logic [BEAT_W-1:0] beat_q [BEATS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      pending_q <= 1'b0;
      addr_q    <= '0;
      way_q     <= '0;
    end else begin
      if (ld_acc_i) begin
        valid_q <= 1'b1;
        addr_q  <= ld_addr_i;
        way_q   <= ld_way_i;
      end else if (rb_acc_i || drain_last_i) begin
        valid_q <= 1'b0;
      end
      // fill in flight until done or retried
      if (ld_acc_i)                     pending_q <= 1'b1;
      else if (rb_acc_i || fill_done_i) pending_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_beat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       beat_q[g] <= '0;
      else if (ld_acc_i) beat_q[g] <= ld_line_i[g*BEAT_W +: BEAT_W];
    end
  end

  assign valid_o   = valid_q;
  assign pending_o = pending_q;
  assign addr_o    = addr_q;
  assign way_o     = way_q;
  assign rd_data_o = beat_q[rd_sel_i];
  assign dr_data_o = beat_q[dr_sel_i];
endmodule

// File: rtl/cob_arb.sv
module cob_arb
  import cob_pkg::*;
#(
  parameter int LA_W = 27
) (
  input  logic            req_i,
  input  logic            write_i,
  input  logic            victim_dirty_i,
  input  logic [LA_W-1:0] addr_i,
  input  logic            buf_valid_i,
  input  logic [LA_W-1:0] buf_addr_i,
  output fill_verdict_e   verdict_o
);
  logic match;
  assign match = buf_valid_i && (addr_i == buf_addr_i);

  always_comb begin
    if (!req_i)                                      verdict_o = VERD_NONE;
    else if (!write_i && match)                      verdict_o = VERD_SERVE;
    else if (victim_dirty_i && buf_valid_i && !match) verdict_o = VERD_CANCEL;
    else                                             verdict_o = VERD_GO;
  end
endmodule

// File: rtl/cob_drain.sv
module cob_drain #(
  parameter int BEATS = 4,
  localparam int BI_W = $clog2(BEATS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ready_i,
  input  logic            ack_i,
  output logic            req_o,
  output logic [BI_W-1:0] beat_o,
  output logic            last_o
);
  localparam logic [BI_W-1:0] LAST = BI_W'(BEATS - 1);
  logic [BI_W-1:0] cnt_q;

  assign req_o  = ready_i;
  assign beat_o = cnt_q;
  assign last_o = ready_i && ack_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (ready_i && ack_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/cob_unit.sv
module cob_unit
  import cob_pkg::*;
#(
  parameter int LA_W   = 27,
  parameter int BEAT_W = 64,
  parameter int BEATS  = 4,
  parameter int WAYS   = 4,
  localparam int LINE_W = BEATS * BEAT_W,
  localparam int BI_W   = $clog2(BEATS),
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [LA_W-1:0]   ld_addr_i,
  input  logic [WAY_W-1:0]  ld_way_i,
  input  logic [LINE_W-1:0] ld_line_i,
  input  logic              fill_req_i,
  input  logic              fill_write_i,
  input  logic              fill_victim_dirty_i,
  input  logic [LA_W-1:0]   fill_addr_i,
  input  logic              fill_done_i,
  output logic              fill_go_o,
  output logic              fill_cancel_o,
  output logic              buf_serve_o,
  input  logic [BI_W-1:0]   rd_beat_i,
  output logic [BEAT_W-1:0] rd_data_o,
  input  logic              retry_i,
  output logic              rb_valid_o,
  output logic [LA_W-1:0]   rb_addr_o,
  output logic [WAY_W-1:0]  rb_way_o,
  output logic              drain_req_o,
  input  logic              drain_ack_i,
  output logic [LA_W-1:0]   drain_addr_o,
  output logic [BI_W-1:0]   drain_beat_o,
  output logic [BEAT_W-1:0] drain_data_o,
  output logic              cob_valid_o
);
  logic             valid, pending, ld_acc, rb_acc, drain_last;
  logic [LA_W-1:0]  addr;
  logic [WAY_W-1:0] way;
  fill_verdict_e    verdict;

  assign ld_acc = ld_i && !valid;
  assign rb_acc = retry_i && pending;

  cob_store #(.LA_W(LA_W), .BEAT_W(BEAT_W), .BEATS(BEATS), .WAY_W(WAY_W)) u_store (
    .clk_i, .rst_ni,
    .ld_acc_i(ld_acc), .ld_addr_i, .ld_way_i, .ld_line_i,
    .rb_acc_i(rb_acc), .drain_last_i(drain_last), .fill_done_i,
    .rd_sel_i(rd_beat_i), .dr_sel_i(drain_beat_o),
    .valid_o(valid), .pending_o(pending), .addr_o(addr), .way_o(way),
    .rd_data_o, .dr_data_o(drain_data_o)
  );

  cob_arb #(.LA_W(LA_W)) u_arb (
    .req_i(fill_req_i), .write_i(fill_write_i), .victim_dirty_i(fill_victim_dirty_i),
    .addr_i(fill_addr_i), .buf_valid_i(valid), .buf_addr_i(addr), .verdict_o(verdict)
  );

  cob_drain #(.BEATS(BEATS)) u_drain (
    .clk_i, .rst_ni,
    .ready_i(valid && !pending), .ack_i(drain_ack_i),
    .req_o(drain_req_o), .beat_o(drain_beat_o), .last_o(drain_last)
  );

  assign fill_go_o     = (verdict == VERD_GO);
  assign fill_cancel_o = (verdict == VERD_CANCEL) || (verdict == VERD_SERVE);
  assign buf_serve_o   = (verdict == VERD_SERVE);
  assign rb_valid_o    = rb_acc;
  assign rb_addr_o     = addr;
  assign rb_way_o      = way;
  assign drain_addr_o  = addr;
  assign cob_valid_o   = valid;
endmodule

// File: rtl/cob_unit_chk.sv
module cob_unit_chk #(
  parameter int LA_W  = 27,
  parameter int BEATS = 4,
  localparam int BI_W = $clog2(BEATS)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ld_i,
  input logic            fill_req_i,
  input logic            fill_write_i,
  input logic            fill_victim_dirty_i,
  input logic [LA_W-1:0] fill_addr_i,
  input logic            fill_go_o,
  input logic            fill_cancel_o,
  input logic            buf_serve_o,
  input logic            retry_i,
  input logic            rb_valid_o,
  input logic            drain_req_o,
  input logic            drain_ack_i,
  input logic [LA_W-1:0] drain_addr_o,
  input logic [BI_W-1:0] drain_beat_o,
  input logic            cob_valid_o
);
  localparam logic [BI_W-1:0] LAST = BI_W'(BEATS - 1);

  AST_RESET_IDLE: assert property (@(posedge clk_i) !rst_ni |=> !cob_valid_o || !rst_ni); // R1
  AST_LOAD_FULL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i && cob_valid_o |=> $stable(drain_addr_o)); // R3
  AST_CANCEL_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_i && fill_victim_dirty_i && cob_valid_o && (fill_addr_i != drain_addr_o)
    |-> fill_cancel_o && !fill_go_o); // R4
  AST_WRITE_MATCH_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_i && fill_write_i && cob_valid_o && (fill_addr_i == drain_addr_o) |-> fill_go_o); // R5
  AST_SERVE_NO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_i && !fill_write_i && cob_valid_o && (fill_addr_i == drain_addr_o)
    |-> buf_serve_o && !fill_go_o); // R6
  AST_ROLLBACK_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_valid_o |=> !cob_valid_o); // R8
  AST_NO_DRAIN_ON_ROLLBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_valid_o |-> !drain_req_o); // R9
  AST_HOLD_UNTIL_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_req_o && drain_ack_i && (drain_beat_o != LAST) |=> cob_valid_o); // R10
  AST_LAST_BEAT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_req_o && drain_ack_i && (drain_beat_o == LAST) |=> !cob_valid_o); // R10
  AST_RETRY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_i && drain_req_o |-> !rb_valid_o); // R11
endmodule

bind cob_unit cob_unit_chk #(.LA_W(LA_W), .BEATS(BEATS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ld_i),
  .fill_req_i(fill_req_i), .fill_write_i(fill_write_i),
  .fill_victim_dirty_i(fill_victim_dirty_i), .fill_addr_i(fill_addr_i),
  .fill_go_o(fill_go_o), .fill_cancel_o(fill_cancel_o), .buf_serve_o(buf_serve_o),
  .retry_i(retry_i), .rb_valid_o(rb_valid_o),
  .drain_req_o(drain_req_o), .drain_ack_i(drain_ack_i), .drain_addr_o(drain_addr_o),
  .drain_beat_o(drain_beat_o), .cob_valid_o(cob_valid_o)
);

// File: tb/cob_unit_bench.sv
module cob_unit_bench;
  localparam int LA_W = 27, BEAT_W = 64, BEATS = 4, WAYS = 4;
  localparam int LINE_W = BEATS * BEAT_W, BI_W = 2, WAY_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              ld = 0, fill_req = 0, fill_write = 0, fill_dirty = 0, fill_done = 0;
  logic              retry = 0, drain_ack = 0;
  logic [LA_W-1:0]   ld_addr = '0, fill_addr = '0;
  logic [WAY_W-1:0]  ld_way = '0;
  logic [LINE_W-1:0] ld_line = '0;
  logic [BI_W-1:0]   rd_beat = '0;
  logic              fill_go, fill_cancel, buf_serve, rb_valid, drain_req, cob_valid;
  logic [BEAT_W-1:0] rd_data, drain_data;
  logic [LA_W-1:0]   rb_addr, drain_addr;
  logic [WAY_W-1:0]  rb_way;
  logic [BI_W-1:0]   drain_beat;

  cob_unit #(.LA_W(LA_W), .BEAT_W(BEAT_W), .BEATS(BEATS), .WAYS(WAYS)) u_cob_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_i(ld), .ld_addr_i(ld_addr), .ld_way_i(ld_way), .ld_line_i(ld_line),
    .fill_req_i(fill_req), .fill_write_i(fill_write), .fill_victim_dirty_i(fill_dirty),
    .fill_addr_i(fill_addr), .fill_done_i(fill_done),
    .fill_go_o(fill_go), .fill_cancel_o(fill_cancel), .buf_serve_o(buf_serve),
    .rd_beat_i(rd_beat), .rd_data_o(rd_data),
    .retry_i(retry), .rb_valid_o(rb_valid), .rb_addr_o(rb_addr), .rb_way_o(rb_way),
    .drain_req_o(drain_req), .drain_ack_i(drain_ack), .drain_addr_o(drain_addr),
    .drain_beat_o(drain_beat), .drain_data_o(drain_data), .cob_valid_o(cob_valid)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  logic              m_valid = 0, m_pending = 0;
  logic [LA_W-1:0]   m_addr = '0;
  logic [WAY_W-1:0]  m_way = '0;
  logic [BEAT_W-1:0] m_beat [BEATS];
  int                m_cnt = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected verdict {go, cancel, serve}
  function automatic logic [2:0] exp_verdict(input logic req, input logic wr, input logic dirty,
                                             input logic match, input logic full);
    if (!req)                      return 3'b000;
    if (!wr && match)              return 3'b011;
    if (dirty && full && !match)   return 3'b010;
    return 3'b100;
  endfunction

  task automatic fill_tag(output string t, input logic wr, input logic dirty, input logic match);
    if (!wr && match)                 t = "R6";
    else if (wr && match && dirty)    t = "R5";
    else if (dirty && m_valid)        t = "R4";
    else                              t = "R7";
  endtask

  task automatic new_line();
    ld_line = '0;
    for (int k = 0; k < BEATS; k++)
      ld_line[k*BEAT_W +: BEAT_W] = {$urandom(), $urandom()};
  endtask

  // inputs already driven after a falling edge
  task automatic cycle();
    logic match, rb_e, dfire;
    logic [2:0] v;
    string t;
    #5;
    match = m_valid && (fill_addr == m_addr);
    v = exp_verdict(fill_req, fill_write, fill_dirty, match, m_valid);
    fill_tag(t, fill_write, fill_dirty, match);
    chk(cob_valid == m_valid, "R2/R10 valid", 64'(cob_valid), 64'(m_valid));
    chk({fill_go, fill_cancel, buf_serve} == v, t, 64'({fill_go, fill_cancel, buf_serve}), 64'(v));
    if (m_valid) begin
      chk(rd_data == m_beat[rd_beat], "R6 rd_data", rd_data, m_beat[rd_beat]);
      chk(drain_addr == m_addr, "R3 addr", 64'(drain_addr), 64'(m_addr));
    end
    rb_e = retry && m_pending;
    chk(rb_valid == rb_e, rb_e ? "R8 rb_valid" : "R11 rb_valid", 64'(rb_valid), 64'(rb_e));
    if (rb_e) chk(rb_addr == m_addr && rb_way == m_way, "R8 rb_addr/way",
                  64'({rb_addr, rb_way}), 64'({m_addr, m_way}));
    chk(drain_req == (m_valid && !m_pending), "R9 drain_req", 64'(drain_req), 64'(m_valid && !m_pending));
    if (m_valid && !m_pending) begin
      chk(drain_beat == BI_W'(m_cnt), "R9 drain_beat", 64'(drain_beat), 64'(m_cnt));
      chk(drain_data == m_beat[m_cnt], "R9 drain_data", drain_data, m_beat[m_cnt]);
    end
    // model update
    dfire = m_valid && !m_pending && drain_ack;
    if (rb_e) begin
      m_valid = 0; m_pending = 0; m_cnt = 0;
    end else begin
      if (dfire) begin
        if (m_cnt == BEATS - 1) begin m_valid = 0; m_cnt = 0; end
        else m_cnt++;
      end
      if (fill_done && m_pending) m_pending = 0;
      if (ld && !m_valid) begin
        m_valid = 1; m_pending = 1; m_addr = ld_addr; m_way = ld_way; m_cnt = 0;
        for (int k = 0; k < BEATS; k++) m_beat[k] = ld_line[k*BEAT_W +: BEAT_W];
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    ld = 0; fill_req = 0; fill_write = 0; fill_dirty = 0; fill_done = 0;
    retry = 0; drain_ack = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_c0b5));
    for (int k = 0; k < BEATS; k++) m_beat[k] = '0;
    repeat (3) @(negedge clk);
    chk(!cob_valid && !drain_req && !rb_valid, "R1 reset", 64'({cob_valid, drain_req, rb_valid}), 64'd0);
    rst_n = 1;
    @(negedge clk);

    // directed: load, illegal load, verdicts, retry after write-match go
    idle(); ld = 1; ld_addr = 27'h0123; ld_way = 2'd2; new_line(); cycle();
    idle(); chk(cob_valid, "R2 loaded", 64'(cob_valid), 64'd1);
    ld = 1; ld_addr = 27'h0777; new_line(); cycle();   // full: must be ignored
    idle(); chk(drain_addr == 27'h0123, "R3 load while full", 64'(drain_addr), 64'h123);
    for (int b = 0; b < BEATS; b++) begin rd_beat = BI_W'(b); cycle(); end
    fill_req = 1; fill_write = 1; fill_dirty = 1; fill_addr = 27'h0123; cycle();
    fill_write = 0; fill_dirty = 1; cycle();
    fill_addr = 27'h0456; cycle();
    fill_dirty = 0; cycle();
    idle(); retry = 1; cycle();
    idle(); chk(!cob_valid, "R8 empty after retry", 64'(cob_valid), 64'd0);
    fill_req = 1; fill_dirty = 1; cycle();
    // directed drain with gaps
    idle(); ld = 1; ld_addr = 27'h0abc; ld_way = 2'd1; new_line(); cycle();
    idle(); drain_ack = 1; cycle();                     // pending: no drain
    idle(); fill_done = 1; cycle();
    idle(); retry = 1; cycle();                         // not pending: ignored
    for (int b = 0; b < BEATS; b++) begin
      idle(); cycle();
      drain_ack = 1; cycle();
    end
    idle(); chk(!cob_valid, "R10 empty after last", 64'(cob_valid), 64'd0);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      idle();
      if (!m_valid && ($urandom() % 10 < 4)) begin   // loads only while empty
        ld = 1; ld_addr = LA_W'($urandom() % 64); ld_way = WAY_W'($urandom()); new_line();
      end
      fill_req   = ($urandom() % 2) == 0;
      fill_write = ($urandom() % 2) == 0;
      fill_dirty = ($urandom() % 3) != 0;
      fill_addr  = ($urandom() % 2 == 0) ? m_addr : LA_W'($urandom() % 64);
      fill_done  = m_pending && ($urandom() % 10 < 3);
      retry      = ($urandom() % 10) == 0;
      drain_ack  = ($urandom() % 2) == 0;
      rd_beat    = BI_W'($urandom());
      cycle();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule